// File: doc/BRIEF.md
# Programmable I2C Master Clock Generator

This block produces the serial clock of an I2C master. It derives the low-phase and high-phase lengths from a 5-bit clock-select code and a standard/fast mode input. It sequences START, repeated START and STOP on the data line, and drives both lines as open-drain pull-downs. The clock pin is read back through an external filtered input. The high-phase count begins only once that input is seen high, so slow rise times, slaves that stretch the clock, and other masters all lengthen the period. A pull-down by another master during the counted high phase makes the generator drop into a fresh low phase.

A separate shift engine uses two strobes. `changeStrobe` tells it when it may change SDA during a low phase, and `sampleStrobe` tells it when to capture SDA at the start of a high phase. While the shift engine holds `holdLow` (a pending byte-end interrupt), the clock is parked low. A fast-mode code below 8 is illegal. It is reported on `codeErr`, and a start request is then refused.

Top module: `scl_timing_gen`

## Requirements
- R1: The divisor m is 65 plus the code in standard mode (`fastMode`=0) and the code plus 1 in fast mode (`fastMode`=1). Fast-mode codes 8 to 31 are legal, and code 8 gives m = 9 with `codeErr`=0.
- R2: In fast mode, codes 0 to 7 raise `codeErr`. A `startReq` is then ignored: `busy`, `sclDriveLow` and `sdaDriveLow` stay 0.
- R3: Each ordinary low phase drives `sclDriveLow`=1 for exactly m cycles when `holdLow` is 0.
- R4: In each high phase SCL is released. The generator waits until `sclIn` reads 1, then stays released for a base count from that first high cycle: m in standard mode and floor(m/2) in fast mode. With a two-cycle filter delay, this gives high times of m+2 and floor(m/2)+2.
- R5: If `sclIn` reads 0 during the counted high phase, the generator drives SCL low on the next cycle and restarts a full low phase of m cycles.
- R6: From idle, `startReq` releases both lines for the base count after `sclIn` is high. It then pulls SDA low and pulls SCL low after a hold of base-2 cycles (m-2 standard, floor(m/2)-2 fast).
- R7: A `stopReq` taken while busy acts at the end of the current low phase. SCL stays low for a further m cycles with SDA low. SCL is then released, SDA is released the base count after `sclIn` reads high, and `busy` returns to 0.
- R8: `changeStrobe` pulses once in each ordinary low phase, exactly 5 cycles after SCL went low. After a START, SDA stays pulled low until that pulse.
- R9: `sampleStrobe` pulses for one cycle per high phase, in the first cycle `sclIn` reads 1 while SCL is released.
- R10: While `holdLow` is 1 in a low phase, SCL stays driven low. The phase ends in the first cycle in which `holdLow` is 0 and the m-cycle count has expired.
- R11: A `startReq` while busy is taken at the end of the current low phase. It produces the setup and hold of R6 without leaving busy, giving a repeated START.
- R12: During and right after reset, `sclDriveLow`, `sdaDriveLow`, `busy` and both strobes are 0. Whenever `busy` is 0, both drive outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 5 | Clock-select code |
| fastMode | input | 1 | 1 selects fast mode, 0 standard |
| startReq | input | 1 | One-cycle request for START or repeated START |
| stopReq | input | 1 | One-cycle request for STOP |
| holdLow | input | 1 | Keeps SCL parked low in a low phase |
| sclIn | input | 1 | Filtered level of the SCL pin |
| sclDriveLow | output | 1 | Open-drain pull-down for SCL |
| sdaDriveLow | output | 1 | Pull-down for SDA during START/STOP sequencing |
| sampleStrobe | output | 1 | SDA capture point at start of high phase |
| changeStrobe | output | 1 | SDA change point inside the low phase |
| busy | output | 1 | Generator is between START and end of STOP |
| codeErr | output | 1 | Illegal fast-mode clock-select code |

## Verification
Two decisions meet at the same low-phase expiry: the `holdLow` park and a pending STOP. The bench raises `stopReq` during a high phase and then holds `holdLow` from the first cycle of the next low phase for longer than m. The expected result is one merged low run of hold length plus one plus m, followed by the STOP setup. A second collision places another master's pull-down inside the counted high phase, where it competes with the high-count expiry. The bench judges this by the cut-short high run of five cycles and a full m-cycle restart. It also releases that pull-down late to check that the following high phase is stretched by exactly the extra wait.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START_SU,
    ST_START_HD,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LOW,
    ST_STOP_SU
  } genState_e;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic ldLow;
    logic ldHigh;
    logic ldHold;
  } dpCmd_t;

endpackage

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int STD_OFFSET = 65,
  parameter int FAST_MIN   = 8,
  parameter int CHANGE_DLY = 5,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] clkSel,
  input  logic              fastMode,
  input  dpCmd_t            cmd,
  output logic              cntZero,
  output logic              changePt,
  output logic              codeErr
);

  localparam logic [CNT_W-1:0] OFFS  = CNT_W'(STD_OFFSET);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_CHG = CNT_W'(CHANGE_DLY + 1);
  localparam logic [CODE_W-1:0] FMIN = CODE_W'(FAST_MIN);

  logic [CNT_W-1:0] mVal;
  logic [CNT_W-1:0] hiBase;
  logic [CNT_W-1:0] holdLen;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    mVal    = fastMode ? (CNT_W'(clkSel) + C_ONE) : (CNT_W'(clkSel) + OFFS);
    hiBase  = fastMode ? (mVal >> 1) : mVal;
    holdLen = hiBase - C_TWO;
    codeErr = fastMode && (clkSel < FMIN);
  end

  // single down-counter shared by every timed phase
  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (cmd.ldLow)   cnt <= mVal - C_ONE;
    else if (cmd.ldHigh)  cnt <= hiBase - C_TWO;
    else if (cmd.ldHold)  cnt <= holdLen - C_ONE;
    else if (cnt != '0)   cnt <= cnt - C_ONE;
  end

  assign cntZero  = (cnt == '0);
  assign changePt = (cnt == (mVal - C_CHG));

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   stopReq,
  input  logic   holdLow,
  input  logic   sclIn,
  input  logic   cntZero,
  input  logic   changePt,
  input  logic   codeErr,
  output dpCmd_t cmd,
  output logic   sclDriveLow,
  output logic   sdaDriveLow,
  output logic   sampleStrobe,
  output logic   changeStrobe,
  output logic   busy
);

  genState_e state, nState;
  logic seen, nSeen;
  logic startPend, nStartPend;
  logic stopPend, nStopPend;
  logic sdaHold;
  logic released;

  assign released = (state == ST_START_SU) || (state == ST_HIGH) || (state == ST_STOP_SU);

  always_comb begin
    nState     = state;
    nSeen      = seen;
    nStartPend = startPend | startReq;
    nStopPend  = stopPend | stopReq;
    cmd        = '0;
    if (state == ST_IDLE) begin
      nStartPend = 1'b0;
      nStopPend  = 1'b0;
      if (startReq && !codeErr) begin
        nState = ST_START_SU;
        nSeen  = 1'b0;
      end
    end else if (released) begin
      if (!seen) begin
        if (sclIn) begin
          nSeen      = 1'b1;
          cmd.ldHigh = 1'b1;
        end
      end else if ((state == ST_HIGH) && !sclIn) begin
        nState    = ST_LOW;
        cmd.ldLow = 1'b1;
      end else if (cntZero) begin
        case (state)
          ST_START_SU: begin
            nState     = ST_START_HD;
            cmd.ldHold = 1'b1;
          end
          ST_HIGH: begin
            nState    = ST_LOW;
            cmd.ldLow = 1'b1;
          end
          default: begin
            nState     = ST_IDLE;
            nStartPend = 1'b0;
            nStopPend  = 1'b0;
          end
        endcase
      end
    end else if (state == ST_START_HD) begin
      if (cntZero) begin
        nState    = ST_LOW;
        cmd.ldLow = 1'b1;
      end
    end else if (state == ST_LOW) begin
      if (cntZero && !holdLow) begin
        nSeen = 1'b0;
        if (startPend) begin
          nState     = ST_START_SU;
          nStartPend = startReq;
        end else if (stopPend) begin
          nState    = ST_STOP_LOW;
          nStopPend = stopReq;
          cmd.ldLow = 1'b1;
        end else begin
          nState = ST_HIGH;
        end
      end
    end else begin
      if (cntZero && !holdLow) begin
        nState = ST_STOP_SU;
        nSeen  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      seen      <= 1'b0;
      startPend <= 1'b0;
      stopPend  <= 1'b0;
      sdaHold   <= 1'b0;
    end else begin
      state     <= nState;
      seen      <= nSeen;
      startPend <= nStartPend;
      stopPend  <= nStopPend;
      if ((nState == ST_START_HD) && (state != ST_START_HD)) sdaHold <= 1'b1;
      else if (changeStrobe || (nState == ST_IDLE))          sdaHold <= 1'b0;
    end
  end

  assign sclDriveLow  = (state == ST_LOW) || (state == ST_STOP_LOW);
  assign sdaDriveLow  = sdaHold || (state == ST_STOP_LOW) || (state == ST_STOP_SU);
  assign sampleStrobe = (state == ST_HIGH) && !seen && sclIn;
  assign changeStrobe = (state == ST_LOW) && changePt;
  assign busy         = (state != ST_IDLE);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int CODE_W     = 5,
  parameter int STD_OFFSET = 65,
  parameter int FAST_MIN   = 8,
  parameter int CHANGE_DLY = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] clkSel,
  input  logic              fastMode,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              holdLow,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              sampleStrobe,
  output logic              changeStrobe,
  output logic              busy,
  output logic              codeErr
);

  localparam int MAX_M = STD_OFFSET + (1 << CODE_W) - 1;
  localparam int CNT_W = $clog2(MAX_M + 1);

  dpCmd_t cmd;
  logic   cntZero;
  logic   changePt;

  scl_gen_dp #(
    .CODE_W(CODE_W), .STD_OFFSET(STD_OFFSET), .FAST_MIN(FAST_MIN),
    .CHANGE_DLY(CHANGE_DLY), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .fastMode(fastMode),
    .cmd(cmd), .cntZero(cntZero), .changePt(changePt), .codeErr(codeErr)
  );

  scl_gen_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .holdLow(holdLow), .sclIn(sclIn), .cntZero(cntZero), .changePt(changePt),
    .codeErr(codeErr), .cmd(cmd), .sclDriveLow(sclDriveLow),
    .sdaDriveLow(sdaDriveLow), .sampleStrobe(sampleStrobe),
    .changeStrobe(changeStrobe), .busy(busy)
  );

endmodule

// File: rtl/scl_gen_chk.sv
module scl_gen_chk (
  input logic clk,
  input logic rstN,
  input logic holdLow,
  input logic sclIn,
  input logic codeErr,
  input logic busy,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic sampleStrobe,
  input logic changeStrobe
);

  // R2
  err_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && codeErr) |=> !busy);

  // R9
  sample_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> (sclIn && !sclDriveLow));

  // R8
  change_dly_chk: assert property (@(posedge clk) disable iff (!rstN)
    changeStrobe |-> (sclDriveLow && $past(sclDriveLow, 5)));

  // R10
  hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdLow && sclDriveLow) |=> sclDriveLow);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStrobe && changeStrobe));

endmodule

bind scl_timing_gen scl_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .holdLow(holdLow), .sclIn(sclIn), .codeErr(codeErr),
  .busy(busy), .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
  .sampleStrobe(sampleStrobe), .changeStrobe(changeStrobe)
);

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;

  localparam int K_LOW = 0, K_HIGH = 1, K_HOLD = 2, K_CHANGE = 3, K_STOPSU = 4;

  typedef struct {
    int    kind;
    int    val;
    string req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] clkSel = 5'd0;
  logic       fastMode = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic       holdLow = 1'b0;
  logic       otherLow = 1'b0;
  logic       pinS1 = 1'b1;
  logic       pinS2 = 1'b1;
  logic       sclIn;
  logic       sclDriveLow, sdaDriveLow, sampleStrobe, changeStrobe, busy, codeErr;

  int errors = 0;
  int checks = 0;
  int tNow = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  // open-drain pin with a two-cycle filtered read-back
  always @(posedge clk) begin
    pinS1 <= !(sclDriveLow || otherLow);
    pinS2 <= pinS1;
    tNow  <= tNow + 1;
  end
  assign sclIn = pinS2;

  scl_timing_gen u0 (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .fastMode(fastMode),
    .startReq(startReq), .stopReq(stopReq), .holdLow(holdLow), .sclIn(sclIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .sampleStrobe(sampleStrobe), .changeStrobe(changeStrobe),
    .busy(busy), .codeErr(codeErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushE(input int k, input int v, input string r);
    expItem_t it;
    it.kind = k; it.val = v; it.req = r;
    expQ.push_back(it);
  endtask

  task automatic popCmp(input int k, input int v);
    expItem_t it;
    if (expQ.size() == 0) begin
      check(1'b0, "unexpected event", k * 1000 + v, -1);
    end else begin
      it = expQ.pop_front();
      check((it.kind == k) && (it.val == v), it.req, k * 1000 + v, it.kind * 1000 + it.val);
    end
  endtask

  // monitor: measures phases and pops the expected queue
  logic prevScl = 1'b0, prevSda = 1'b0, haveLow = 1'b0, sdaArmed = 1'b0;
  int tEdge = 0, tSda = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (sclDriveLow && !prevScl) begin
        if (haveLow) popCmp(K_HIGH, tNow - tEdge);
        if (sdaArmed) begin popCmp(K_HOLD, tNow - tSda); sdaArmed = 1'b0; end
        tEdge = tNow; haveLow = 1'b1;
      end else if (!sclDriveLow && prevScl) begin
        popCmp(K_LOW, tNow - tEdge);
        tEdge = tNow;
      end
      if (sdaDriveLow && !prevSda && !sclDriveLow) begin sdaArmed = 1'b1; tSda = tNow; end
      if (!sdaDriveLow && prevSda && !sclDriveLow) popCmp(K_STOPSU, tNow - tEdge);
      if (changeStrobe) popCmp(K_CHANGE, tNow - tEdge);
      if (sampleStrobe) check(sclIn && !sclDriveLow, "R9 sample point", {30'd0, sclIn, sclDriveLow}, 2);
      if (!busy) haveLow = 1'b0;
      prevScl = sclDriveLow;
      prevSda = sdaDriveLow;
    end
  end

  task automatic waitSample();
    do @(negedge clk); while (!sampleStrobe);
  endtask

  task automatic pulse(input int which);
    if (which == 0) startReq = 1'b1; else stopReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0;
  endtask

  task automatic finishFrame(input string tag);
    do @(negedge clk); while (busy);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, {tag, " all phases seen"}, expQ.size(), 0);
    check(!sclDriveLow && !sdaDriveLow, "R12 idle after frame", {30'd0, sclDriveLow, sdaDriveLow}, 0);
    expQ.delete();
  endtask

  task automatic runFrame(input int code, input bit fast, input int nbits, input int holdX, input bit rep);
    int m = fast ? code + 1 : 65 + code;
    int hb = fast ? m / 2 : m;
    int h = hb + 2;
    int hd = hb - 2;
    @(negedge clk);
    clkSel = 5'(code); fastMode = fast;
    @(negedge clk);
    check(codeErr == 1'b0, "R1 legal code no error", codeErr, 0);
    pushE(K_HOLD, hd, "R6 start hold");
    pushE(K_CHANGE, 5, "R8 change point");
    for (int i = 0; i < nbits; i++) begin
      pushE(K_LOW, m, "R3 R1 low phase");
      pushE(K_HIGH, h, "R4 high phase");
      pushE(K_CHANGE, 5, "R8 change point");
    end
    if (rep) begin
      pushE(K_LOW, m, "R3 low phase");
      pushE(K_HIGH, h + hd, "R11 repeated start gap");
      pushE(K_HOLD, hd, "R11 repeated start hold");
      pushE(K_CHANGE, 5, "R8 change point");
      pushE(K_LOW, m, "R3 low phase");
      pushE(K_HIGH, h, "R4 high phase");
      pushE(K_CHANGE, 5, "R8 change point");
    end
    pushE(K_LOW, (holdX > 0 ? holdX + 1 : m) + m, "R7 R10 last low plus stop low");
    pushE(K_STOPSU, h, "R7 stop setup");
    pulse(0);
    for (int i = 0; i < nbits; i++) waitSample();
    if (rep) begin
      pulse(0);
      waitSample();
    end
    pulse(1);
    if (holdX > 0) begin
      do @(negedge clk); while (!sclDriveLow);
      holdLow = 1'b1;
      repeat (holdX) @(negedge clk);
      holdLow = 1'b0;
    end
    finishFrame("R7 frame");
  endtask

  task automatic runSync(input int code);
    int m = 65 + code;
    int hb = m;
    @(negedge clk);
    clkSel = 5'(code); fastMode = 1'b0;
    pushE(K_HOLD, hb - 2, "R6 start hold");
    pushE(K_CHANGE, 5, "R8 change point");
    pushE(K_LOW, m, "R3 low phase");
    pushE(K_HIGH, 5, "R5 high cut by other master");
    pushE(K_CHANGE, 5, "R8 change after restart");
    pushE(K_LOW, m, "R5 restarted low phase");
    pushE(K_HIGH, hb + 29, "R4 stretched high phase");
    pushE(K_CHANGE, 5, "R8 change point");
    pushE(K_LOW, 2 * m, "R7 last low plus stop low");
    pushE(K_STOPSU, hb + 2, "R7 stop setup");
    pulse(0);
    waitSample();
    otherLow = 1'b1;
    repeat (m + 30) @(negedge clk);
    otherLow = 1'b0;
    waitSample();
    pulse(1);
    finishFrame("R5 sync frame");
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check({sclDriveLow, sdaDriveLow, busy, sampleStrobe, changeStrobe} == 5'd0,
          "R12 reset outputs", {sclDriveLow, sdaDriveLow, busy, sampleStrobe, changeStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !sclDriveLow, "R12 after reset", {30'd0, busy, sclDriveLow}, 0);

    // R2 illegal fast code
    fastMode = 1'b1; clkSel = 5'd5;
    @(negedge clk);
    check(codeErr == 1'b1, "R2 code 5 flagged", codeErr, 1);
    pulse(0);
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        if (busy || sclDriveLow || sdaDriveLow) quiet = 1'b0;
        @(negedge clk);
      end
      check(quiet, "R2 start ignored", !quiet, 0);
    end
    clkSel = 5'd7;
    @(negedge clk);
    check(codeErr == 1'b1, "R2 code 7 flagged", codeErr, 1);
    fastMode = 1'b0;
    @(negedge clk);
    check(codeErr == 1'b0, "R1 standard code 7 legal", codeErr, 0);

    runFrame(0, 1'b0, 2, 0, 1'b0);
    runFrame(31, 1'b0, 1, 120, 1'b0);
    runFrame(8, 1'b1, 3, 0, 1'b0);
    runFrame(31, 1'b1, 2, 0, 1'b1);
    runSync(2);
    done = 1'b1;
    report();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

endmodule